// File: doc/BRIEF.md
# Strap-Latched Frequency Select Controller

This block decides which CPU frequency code a clock generator runs at. It works together with four shared pins. While power-on reset is held, those pins are inputs. The block samples their levels on every clock edge, so the value present at the last reset edge is the one it keeps. One pin is a mode strap and the other three form a hardware frequency code. After reset is released the captured values stay frozen, and the pin output enables are asserted so that the pins can carry clocks. The enables stay deasserted for the whole reset, so the block never drives a strap while it is being sampled.

A configuration byte, written through a simple write strobe, can override the strapped code with a programmed one. The same byte carries the spread-spectrum flags and a global output-disable bit. From the active code the block produces three registered outputs: the CPU-to-PCI divisor, a nominal CPU frequency, and a one-cycle strobe when the code changes. It also drives two readback bytes that return the strapped frequency bits inverted.

Top module: `strap_fsel_ctrl`

## Requirements
- R1: The strap latch loads `strap_pin_i` on every clock edge while `rst_n` is low. After release it keeps the value from the last low edge, and later pin activity does not change it.
- R2: `pin_oe_o` is 0 during reset. It becomes all ones one clock edge after reset is released, unless outputs are disabled.
- R3: The configuration byte resets to 0x00, which selects the strapped code `strap_pin_i[2:0]`. Bit 3 set to 1 selects the programmed code in bits 6:4 instead. Bits 6:4 have no effect while bit 3 is 0.
- R4: `ratio_o` gives the PCI divisor for the active code: 111→3, 110→4, 101→3, 100→3, and 011, 010, 001, 000→2.
- R5: `nom_freq_o` gives the nominal CPU frequency in 100 kHz units: 111→1002, 110→1333, 101→1120, 100→1030, 011→668, 010→833, 001→750, 000→500.
- R6: After a configuration write that changes the active code, `code_o`, `ratio_o` and `nom_freq_o` change one clock edge later, and `freq_chg_o` is high for exactly that cycle. A write that leaves the code unchanged produces no strobe.
- R7: Three configuration bits drive flag outputs, each reflected directly on its port:
  - bit 1 drives `ss_en_o` (spread enable);
  - bit 2 drives `ss_down_o` (1 selects down-spread, 0 selects center-spread);
  - bit 7 drives `ss_deep_o` (1 selects 0.5 %, 0 selects 0.25 %).
- R8: Configuration bit 0 set to 1 forces `pin_oe_o` and `ref_oe_o` to 0 from the next clock edge onward.
- R9: Both readback bytes have every bit 1 except the strap bits, which appear inverted:
  - `rb_byte4_o` carries ~FS0 in bit 7 and ~FS1 in bit 4;
  - `rb_byte5_o` carries ~FS2 in bit 6.
- R10: The latched mode strap (pin bit 3) sets the function of the shared pin. When it is 0, `stop_in_sel_o` is 1 and `ref_oe_o` is 0, so the pin is the stop input. When it is 1, `stop_in_sel_o` is 0 and `ref_oe_o` follows the pin enables, so the pin is a reference output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; straps are sampled while low |
| strap_pin_i | input | 4 | Shared pin levels: bit 3 mode, bits 2:0 FS2..FS0 |
| cfg_we_i | input | 1 | Write strobe for the configuration byte |
| cfg_wdata_i | input | 8 | Configuration byte write data |
| pin_oe_o | output | 4 | Output enables of the shared pins |
| ref_oe_o | output | 1 | Output enable of the stop/reference shared pin |
| stop_in_sel_o | output | 1 | 1 when the shared pin acts as the stop input |
| code_o | output | 3 | Active frequency code (registered) |
| ratio_o | output | 3 | CPU-to-PCI divisor (registered) |
| nom_freq_o | output | 11 | Nominal CPU frequency in 100 kHz units (registered) |
| freq_chg_o | output | 1 | One-cycle strobe on a code change |
| ss_en_o | output | 1 | Spread-spectrum enable |
| ss_down_o | output | 1 | Down-spread select |
| ss_deep_o | output | 1 | Deeper modulation select |
| rb_byte4_o | output | 8 | Readback byte with inverted FS0 and FS1 |
| rb_byte5_o | output | 8 | Readback byte with inverted FS2 |

## Verification
A corrupted strap latch shows up on `code_o`, `ratio_o` and the readback bytes in the first cycle after reset. It also shows up whenever the code source is switched back to the straps. An override mux that picks the wrong source shows as a wrong divisor one edge after the write. A broken change detector shows as a missing or a spurious `freq_chg_o` pulse in that same cycle. A wrong output-enable state shows on `pin_oe_o` one edge after reset release or one edge after the disable bit is written.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
   localparam int CODE_W  = 3;
   localparam int RATIO_W = 3;
   localparam int FREQ_W  = 11;

   typedef logic [CODE_W-1:0]  code_t;
   typedef logic [RATIO_W-1:0] ratio_t;
   typedef logic [FREQ_W-1:0]  freq_t;

   // configuration byte as a struct, MSB first
   typedef struct packed {
      logic  deep;      // bit 7
      code_t prog_code; // bits 6:4
      logic  use_prog;  // bit 3
      logic  down;      // bit 2
      logic  ss_en;     // bit 1
      logic  tri_all;   // bit 0
   } cfg_t;

   function automatic ratio_t ratio_of(input code_t c);
      case (c)
         3'b111:  ratio_of = 3'd3;
         3'b110:  ratio_of = 3'd4;
         3'b101:  ratio_of = 3'd3;
         3'b100:  ratio_of = 3'd3;
         default: ratio_of = 3'd2;
      endcase
   endfunction

   function automatic freq_t nom_of(input code_t c);
      case (c)
         3'b111:  nom_of = 11'd1002;
         3'b110:  nom_of = 11'd1333;
         3'b101:  nom_of = 11'd1120;
         3'b100:  nom_of = 11'd1030;
         3'b011:  nom_of = 11'd668;
         3'b010:  nom_of = 11'd833;
         3'b001:  nom_of = 11'd750;
         default: nom_of = 11'd500;
      endcase
   endfunction
endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
   parameter int NUM_PINS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                tri_i,
   output logic [NUM_PINS-1:0] strap_o,
   output logic [NUM_PINS-1:0] oe_o
);
   logic [NUM_PINS-1:0] strap_q;
   logic [NUM_PINS-1:0] oe_q;

   // sampling continues through reset; the last reset edge wins
   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= pin_i;
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_oe
      always_ff @(posedge clk) begin
         if (!rst_n) oe_q[i] <= 1'b0;
         else        oe_q[i] <= ~tri_i;
      end
   end

   assign strap_o = strap_q;
   assign oe_o    = oe_q;

   // R1
   strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(strap_q));
endmodule

// File: rtl/fsel_cfg_reg.sv
module fsel_cfg_reg
   import fsel_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we_i,
   input  logic [7:0]  wdata_i,
   input  code_t       strap_code_i,
   output cfg_t        cfg_o,
   output code_t       sel_code_o
);
   cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cfg_q <= '0;
      else if (we_i) cfg_q <= cfg_t'(wdata_i);
   end

   assign cfg_o      = cfg_q;
   assign sel_code_o = cfg_q.use_prog ? cfg_q.prog_code : strap_code_i;
endmodule

// File: rtl/fsel_ratio_stage.sv
module fsel_ratio_stage
   import fsel_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  code_t  sel_code_i,
   input  code_t  reset_code_i,
   output code_t  code_o,
   output ratio_t ratio_o,
   output freq_t  nom_o,
   output logic   chg_o
);
   code_t  code_q;
   ratio_t ratio_q;
   freq_t  nom_q;
   logic   chg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= reset_code_i;
         ratio_q <= ratio_of(reset_code_i);
         nom_q   <= nom_of(reset_code_i);
         chg_q   <= 1'b0;
      end else begin
         code_q  <= sel_code_i;
         ratio_q <= ratio_of(sel_code_i);
         nom_q   <= nom_of(sel_code_i);
         chg_q   <= (sel_code_i != code_q);
      end
   end

   assign code_o  = code_q;
   assign ratio_o = ratio_q;
   assign nom_o   = nom_q;
   assign chg_o   = chg_q;

   // R6
   chg_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_q |-> (code_q != $past(code_q)));
   // R4
   ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_q >= 3'd2) && (ratio_q <= 3'd4));
endmodule

// File: rtl/strap_fsel_ctrl.sv
module strap_fsel_ctrl
   import fsel_pkg::*;
#(
   parameter int NUM_PINS = 4,
   parameter int MODE_IDX = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] strap_pin_i,
   input  logic                cfg_we_i,
   input  logic [7:0]          cfg_wdata_i,
   output logic [NUM_PINS-1:0] pin_oe_o,
   output logic                ref_oe_o,
   output logic                stop_in_sel_o,
   output logic [CODE_W-1:0]   code_o,
   output logic [RATIO_W-1:0]  ratio_o,
   output logic [FREQ_W-1:0]   nom_freq_o,
   output logic                freq_chg_o,
   output logic                ss_en_o,
   output logic                ss_down_o,
   output logic                ss_deep_o,
   output logic [7:0]          rb_byte4_o,
   output logic [7:0]          rb_byte5_o
);
   if (NUM_PINS != CODE_W + 1) begin : g_bad_pins
      $error("NUM_PINS must equal CODE_W + 1");
   end
   if (MODE_IDX != CODE_W) begin : g_bad_mode
      $error("MODE_IDX must sit above the code bits");
   end

   logic [NUM_PINS-1:0] strap;
   cfg_t                cfg;
   code_t               sel_code;

   fsel_strap_latch #(.NUM_PINS(NUM_PINS)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (strap_pin_i),
      .tri_i   (cfg.tri_all),
      .strap_o (strap),
      .oe_o    (pin_oe_o)
   );

   fsel_cfg_reg u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .we_i         (cfg_we_i),
      .wdata_i      (cfg_wdata_i),
      .strap_code_i (strap[CODE_W-1:0]),
      .cfg_o        (cfg),
      .sel_code_o   (sel_code)
   );

   fsel_ratio_stage u_ratio (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_code_i   (sel_code),
      .reset_code_i (strap_pin_i[CODE_W-1:0]),
      .code_o       (code_o),
      .ratio_o      (ratio_o),
      .nom_o        (nom_freq_o),
      .chg_o        (freq_chg_o)
   );

   assign stop_in_sel_o = ~strap[MODE_IDX];
   assign ref_oe_o      = strap[MODE_IDX] & pin_oe_o[MODE_IDX];
   assign ss_en_o       = cfg.ss_en;
   assign ss_down_o     = cfg.down;
   assign ss_deep_o     = cfg.deep;

   always_comb begin
      rb_byte4_o    = 8'hFF;
      rb_byte4_o[7] = ~strap[0];
      rb_byte4_o[4] = ~strap[1];
      rb_byte5_o    = 8'hFF;
      rb_byte5_o[6] = ~strap[2];
   end

   // R8
   tri_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.tri_all |=> (pin_oe_o == '0) && !ref_oe_o);
   // R10
   mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(stop_in_sel_o && ref_oe_o));
endmodule

// File: tb/tb_strap_fsel_ctrl.sv
module tb_strap_fsel_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  strap_pin_i;
   logic        cfg_we_i;
   logic [7:0]  cfg_wdata_i;
   logic [3:0]  pin_oe_o;
   logic        ref_oe_o, stop_in_sel_o, freq_chg_o;
   logic [2:0]  code_o, ratio_o;
   logic [10:0] nom_freq_o;
   logic        ss_en_o, ss_down_o, ss_deep_o;
   logic [7:0]  rb_byte4_o, rb_byte5_o;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   strap_fsel_ctrl dut (.*);

   function automatic int exp_ratio(input logic [2:0] c);
      if (c == 3'b110) return 4;
      if (c == 3'b111 || c == 3'b101 || c == 3'b100) return 3;
      return 2;
   endfunction

   function automatic int exp_nom(input logic [2:0] c);
      int t[8] = '{500, 750, 833, 668, 1030, 1120, 1333, 1002};
      return t[c];
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [3:0] early, input logic [3:0] last);
      @(negedge clk);
      rst_n = 1'b0; cfg_we_i = 1'b0; cfg_wdata_i = 8'h00;
      strap_pin_i = early;
      repeat (3) @(negedge clk);
      chk("R2 oe in reset", pin_oe_o, 0);
      strap_pin_i = last;
      @(negedge clk);
      rst_n = 1'b1;
      strap_pin_i = ~last;   // pins now free to toggle
      @(negedge clk);
   endtask

   task automatic write_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_we_i = 1'b1; cfg_wdata_i = v;
      @(negedge clk);
      cfg_we_i = 1'b0;
   endtask

   task automatic t_strap(input logic [3:0] s);
      do_reset(~s, s);
      chk("R1 code from last reset edge", code_o, s[2:0]);
      chk("R4 ratio", ratio_o, exp_ratio(s[2:0]));
      chk("R5 nominal", nom_freq_o, exp_nom(s[2:0]));
      chk("R2 oe after release", pin_oe_o, 4'hF);
      chk("R6 no strobe after reset", freq_chg_o, 0);
      chk("R9 byte4", rb_byte4_o, {~s[0], 2'b11, ~s[1], 4'hF});
      chk("R9 byte5", rb_byte5_o, {1'b1, ~s[2], 6'h3F});
      chk("R10 stop select", stop_in_sel_o, !s[3]);
      chk("R10 ref oe", ref_oe_o, s[3]);
      chk("R7 spread off at reset", {ss_en_o, ss_down_o, ss_deep_o}, 0);
      repeat (3) @(negedge clk);
      chk("R1 latch held", code_o, s[2:0]);
   endtask

   task automatic t_override(input logic [2:0] strap_code);
      logic [2:0] prev;
      prev = strap_code;
      for (int c = 7; c >= 0; c--) begin
         write_cfg({1'b0, 3'(c), 1'b1, 3'b000});
         chk("R6 code not yet", code_o, prev);
         @(negedge clk);
         chk("R3 override code", code_o, c);
         chk("R4 override ratio", ratio_o, exp_ratio(3'(c)));
         chk("R5 override nominal", nom_freq_o, exp_nom(3'(c)));
         chk("R6 strobe", freq_chg_o, (3'(c) != prev));
         @(negedge clk);
         chk("R6 strobe one cycle", freq_chg_o, 0);
         prev = 3'(c);
      end
   endtask

   task automatic t_ignore(input logic [2:0] strap_code);
      write_cfg(8'h00);
      @(negedge clk);
      chk("R3 back to strap", code_o, strap_code);
      write_cfg({1'b0, ~strap_code, 4'b0000});
      @(negedge clk);
      chk("R3 bits ignored", code_o, strap_code);
      chk("R6 no strobe", freq_chg_o, 0);
   endtask

   task automatic t_spread();
      write_cfg(8'h86);
      chk("R7 flags", {ss_en_o, ss_down_o, ss_deep_o}, 3'b111);
      write_cfg(8'h02);
      chk("R7 center shallow", {ss_en_o, ss_down_o, ss_deep_o}, 3'b100);
   endtask

   task automatic t_tristate();
      write_cfg(8'h01);
      chk("R8 oe one edge later", pin_oe_o, 4'hF);
      @(negedge clk);
      chk("R8 oe off", pin_oe_o, 0);
      chk("R8 ref off", ref_oe_o, 0);
      write_cfg(8'h00);
      @(negedge clk);
      chk("R8 oe back", pin_oe_o, 4'hF);
   endtask

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; strap_pin_i = 4'h0; cfg_we_i = 1'b0; cfg_wdata_i = 8'h00;
      t_strap(4'b1101);
      t_override(3'b101);
      t_ignore(3'b101);
      t_spread();
      t_tristate();
      t_strap(4'b0110);
      t_tristate();
      t_strap(4'b1000);
      t_override(3'b000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule